// File: doc/BRIEF.md
# Serial Configuration Memory Read Engine

This block is the read side of a one-bit-wide configuration store that feeds a programmable logic device while that device loads itself in master serial mode. The loading device supplies the clock. On each clock edge of an active read, the engine steps a bit pointer and presents the next stored bit. The output is modelled as a value plus an enable, so that a wrapper can form a shared three-state line from them.

A stored polarity bit chooses which level of the combined reset/enable pin clears the pointer and which level enables the output. After the final bit has gone out, the engine stops driving and pulls its chain-select output low, so that the next device in a cascade can take over the shared data line. Holding the mode pin low selects programming mode. In that mode a simple synchronous port loads the bit array and the polarity bit, and the read path stays idle. The depth is a parameter; deployments use 65536, 131072 or 262144.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: While reading is enabled (mode_sel=1, sel_n=0, reset pin not at its reset level, not exhausted), each rising clk edge advances the bit pointer by one. bit_out shows the stored bit at the pointer, and the pointer starts at bit 0 after a clear.
- R2: bit_en is 1 only when mode_sel=1, sel_n=0, the reset pin is at its enable level and the array is not exhausted. Whenever bit_en is 0, bit_out is 0.
- R3: A clock edge that samples the reset pin at its reset level sets the pointer to 0 and clears the exhausted state, whatever sel_n is.
- R4: Polarity bit 0 means the reset level is 1 (rst_oe_pin=1 resets, 0 enables). Polarity bit 1 means the reset level is 0. The polarity bit is 0 after rst_n.
- R5: With sel_n=1 the pointer and the exhausted state hold and bit_en is 0.
- R6: The edge that reads the last bit (pointer DEPTH-1) sets the exhausted state. From then on bit_en is 0 and chain_sel_n is 0 while sel_n is 0.
- R7: Once exhausted, the pointer holds without wrapping and chain_sel_n equals sel_n. The first edge at the reset level drives chain_sel_n back to 1, where it stays until the array has been read out to its end again.
- R8: With mode_sel=0, bit_en is 0, chain_sel_n is 1, sel_n has no effect, and the pointer and the exhausted state hold.
- R9: Array writes (ld_we, ld_addr, ld_bit) and polarity writes (pol_we, pol_val) take effect at a clock edge only when mode_sel=0. With mode_sel=1 they are ignored.
- R10: rst_n low clears the pointer, the exhausted state and the polarity bit. bit_en is then 0 and chain_sel_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the loading device |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mode_sel | input | 1 | 1 = read mode, 0 = programming mode |
| sel_n | input | 1 | Device select, active low |
| rst_oe_pin | input | 1 | Combined reset / output enable, level set by polarity bit |
| ld_we | input | 1 | Array write strobe |
| ld_addr | input | $clog2(DEPTH) | Array write address |
| ld_bit | input | 1 | Array write data |
| pol_we | input | 1 | Polarity bit write strobe |
| pol_val | input | 1 | Polarity bit write value |
| bit_out | output | 1 | Serial data value |
| bit_en | output | 1 | Serial data drive enable |
| chain_sel_n | output | 1 | Select for the next device in a cascade, active low |

## Verification
The assertions assume that the select, mode and reset pins change only between clock edges and are stable at the sampling edge, since the engine treats them as synchronous inputs. They also assume that rst_n is applied before the first meaningful edge. The stimulus drives every input on the falling edge and observes the outputs shortly after it, so each rising edge sees settled values. The walk covers pauses, clears during reads, reading past the end, switching the select after exhaustion, both polarity settings and a switch into programming mode in the middle of a read.

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader #(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_sel,
  input  logic                     sel_n,
  input  logic                     rst_oe_pin,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic                     ld_bit,
  input  logic                     pol_we,
  input  logic                     pol_val,
  output logic                     bit_out,
  output logic                     bit_en,
  output logic                     chain_sel_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          store [DEPTH];
  logic [AW-1:0] ptr;
  logic          spent;
  logic          pol;
  logic          clr_lvl;
  logic          reading;

  assign clr_lvl = rst_oe_pin ^ pol;
  assign reading = mode_sel & ~sel_n & ~clr_lvl & ~spent;

  always_ff @(posedge clk) begin
    if (!mode_sel && ld_we) store[ld_addr] <= ld_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= 1'b0;
    end else if (!mode_sel && pol_we) begin
      pol <= pol_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      spent <= 1'b0;
    end else if (mode_sel) begin
      if (clr_lvl) begin
        ptr   <= '0;
        spent <= 1'b0;
      end else if (reading) begin
        if (ptr == LAST) spent <= 1'b1;
        else             ptr   <= ptr + 1'b1;
      end
    end
  end

  assign bit_en      = reading;
  assign bit_out     = reading & store[ptr];
  assign chain_sel_n = ~(mode_sel & spent & ~sel_n);

  p_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !sel_n && !clr_lvl && !spent && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && clr_lvl) |=> (ptr == '0 && !spent));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && sel_n && !clr_lvl) |=> ($stable(ptr) && $stable(spent)));

  p_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !sel_n && !clr_lvl && !spent && ptr == LAST) |=> (spent && ptr == LAST));

  p_nowrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && !(mode_sel && clr_lvl)) |=> (spent && $stable(ptr)));

  p_prog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |=> ($stable(ptr) && $stable(spent)));

  p_pol_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> $stable(pol));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !bit_out);
endmodule

// File: tb/cfg_bitstream_reader_tb.sv
module cfg_bitstream_reader_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [DEPTH-1:0] PAT = 16'hA5C3;
  localparam int NV = 35;
  localparam logic [1:0] VEC [NV] = '{
    2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00,
    2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10,
    2'b00, 2'b10, 2'b01, 2'b00, 2'b00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, sel_n = 1'b1, rst_oe_pin = 1'b0;
  logic ld_we = 1'b0, ld_bit = 1'b0, pol_we = 1'b0, pol_val = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic bit_out, bit_en, chain_sel_n;

  int compared = 0;
  int mismatched = 0;

  logic [DEPTH-1:0] m_mem = '0;
  logic [AW-1:0] m_ptr = '0;
  logic m_spent = 1'b0;
  logic m_pol = 1'b0;

  always #2.5 clk = ~clk;

  cfg_bitstream_reader #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sel_n(sel_n),
    .rst_oe_pin(rst_oe_pin), .ld_we(ld_we), .ld_addr(ld_addr), .ld_bit(ld_bit),
    .pol_we(pol_we), .pol_val(pol_val), .bit_out(bit_out), .bit_en(bit_en),
    .chain_sel_n(chain_sel_n));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {en,out,chain_n} actual %b expected %b (ptr %0d)", req, act, exp, m_ptr);
    end
  endtask

  task automatic step(input logic ms, input logic sn, input logic ro,
                      input logic we, input logic [AW-1:0] wa, input logic wb,
                      input logic pw, input logic pv, input string req);
    logic e_en, e_out, e_ch, clr;
    @(negedge clk);
    mode_sel = ms; sel_n = sn; rst_oe_pin = ro;
    ld_we = we; ld_addr = wa; ld_bit = wb; pol_we = pw; pol_val = pv;
    #1;
    clr   = ro ^ m_pol;
    e_en  = ms & ~sn & ~clr & ~m_spent;
    e_out = e_en & m_mem[m_ptr];
    e_ch  = ~(ms & m_spent & ~sn);
    check(req, {bit_en, bit_out, chain_sel_n}, {e_en, e_out, e_ch});
    if (ms) begin
      if (clr) begin m_ptr = '0; m_spent = 1'b0; end
      else if (!sn && !m_spent) begin
        if (m_ptr == AW'(DEPTH - 1)) m_spent = 1'b1;
        else m_ptr = m_ptr + 1'b1;
      end
    end else begin
      if (we) m_mem[wa] = wb;
      if (pw) m_pol = pv;
    end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {bit_en, bit_out, chain_sel_n}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b0, 1'b0, 1'b1, AW'(i), PAT[i], 1'b0, 1'b0, "R9 load");
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R9 pol load");
    // R9: writes in read mode must be ignored; bit 0 and polarity are checked later
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, ~PAT[0], 1'b1, 1'b1, "R9 ignored write");

    for (int i = 0; i < NV; i++)
      step(1'b1, VEC[i][1], VEC[i][0], 1'b0, '0, 1'b0, 1'b0, 1'b0,
           m_spent ? "R6 R7 exhausted" : "R1 R2 R3 R5 walk");

    // R4: switch polarity, low level now clears
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R4 pol write");
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R4 low clears");
    for (int i = 0; i < 4; i++)
      step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R4 high enables");

    // R8: programming mode mid-read, select ignored, pointer held
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8 prog mode");
    for (int i = 0; i < 3; i++)
      step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8 resume");

    // R7: read to end under inverted polarity, then clear
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R6 R7 to end");
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7 follow");
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7 clear");
    step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7 chain high");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule